// File: doc/BRIEF.md
# Register-Field Multiply-Accumulate Unit

This execution unit serves a 32-bit processor core. It receives an instruction word together with the register-file values that the word selects. From these it produces one of six multiply results: a 32-bit product, a 32-bit product plus a third register, an unsigned 64-bit product, a signed 64-bit product, and either 64-bit product plus the old contents of a destination register pair. The unit pulls the register index fields out of the instruction word itself. It drives them combinationally as read addresses, so the register file can return the operand values in the same cycle. The accumulate, long, signed and set-flags controls arrive as separate pins.

The operation request uses a valid/ready handshake. `in_ready` is high whenever no multiply is in progress. A request is taken on a rising clock edge where both `in_valid` and `in_ready` are high. At that edge every operand, the addend and the old flags are captured. While the unit is busy, `in_ready` is low, and a held `in_valid` waits without effect.

The multiplier steps through the Rs operand 8 bits per cycle. The result side has no back-pressure. `done` is high for exactly one cycle, and the write-back consumer must take the destination indices, data, write enables and flag outputs in that cycle. Because `in_ready` is already high while `done` is high, a new request can overlap the result cycle.

Top module: `regfield_mac`

## Requirements
- R1: The read index outputs follow the instruction word combinationally:
  - Rm index = bits 3:0.
  - Rs index = bits 11:8.
  - low/accumulate index = bits 15:12.
  - high/destination index = bits 19:16.
- R1 (continued): In the result cycle, `dst_a_idx` carries bits 19:16 and `dst_b_idx` carries bits 15:12 of the accepted word.
- R2: With long and accumulate both low, `dst_a_data` is the low 32 bits of Rm × Rs.
- R3: With long low and accumulate high, `dst_a_data` is the low 32 bits of Rm × Rs + Rn, where Rn is the value at the low/accumulate index.
- R4: With long high and signed low, the unit forms the unsigned 64-bit product of Rm and Rs. When accumulate is high, it adds {RdHi, RdLo} modulo 2^64. The upper word goes out on `dst_a_data` and the lower word on `dst_b_data`.
- R5: With long and signed both high, Rm and Rs are sign-extended to 64 bits before the multiply. The optional accumulate is the same wrapping 64-bit add, with the same word placement.
- R6: Write enables are only ever high in the result cycle. `dst_a_we` is always high in that cycle. `dst_b_we` is high in that cycle only for the long forms.
- R7: For a short flag-setting multiply, N (`flags_out` bit 3) equals result bit 31. Z (`flags_out` bit 2) is high exactly when the 32-bit result is zero.
- R8: For a long flag-setting multiply, N equals bit 63 of the result. Z is high only when both result words are zero.
- R9: `flags_we` is high only in the result cycle of an operation accepted with set-flags high. C (bit 1) and V (bit 0) are driven with the values captured at acceptance and are don't-care for checking.
- R10: `done` rises after the fourth rising edge that follows acceptance and stays high for exactly one cycle.
- R11: `in_ready` is low from acceptance until the result cycle. A valid request during that time is ignored. A request presented in the result cycle is accepted.
- R12: All operands, the addend and the controls are captured at acceptance. Changing the inputs afterwards does not alter the result, so a long accumulate uses the pair values present at acceptance.
- R13: After reset, `in_ready` is high and `done`, all write enables and `flags_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit can accept a request |
| instr | input | 32 | Instruction word holding the register fields |
| acc_en | input | 1 | Accumulate control |
| long_en | input | 1 | 64-bit result form |
| signed_en | input | 1 | Signed operands (long form only) |
| setflags | input | 1 | Update N and Z |
| rsrc_m_idx | output | 4 | Read address for Rm |
| rsrc_s_idx | output | 4 | Read address for Rs |
| rsrc_lo_idx | output | 4 | Read address for Rn / RdLo |
| rsrc_hi_idx | output | 4 | Read address for RdHi |
| src_m | input | 32 | Value of Rm |
| src_s | input | 32 | Value of Rs |
| src_lo | input | 32 | Value of Rn / RdLo |
| src_hi | input | 32 | Value of RdHi |
| flags_in | input | 4 | Current {N,Z,C,V} |
| done | output | 1 | Result cycle |
| dst_a_idx | output | 4 | Destination (high word in long form) |
| dst_b_idx | output | 4 | Low-word destination (long form) |
| dst_a_data | output | 32 | Short result or high word |
| dst_b_data | output | 32 | Low word |
| dst_a_we | output | 1 | Write enable for dst_a |
| dst_b_we | output | 1 | Write enable for dst_b |
| flags_we | output | 1 | Flag write enable |
| flags_out | output | 4 | New {N,Z,C,V} |

## Verification
The assertions take for granted that the inputs matter only at the accepting edge, and that the consumer takes every result in its single `done` cycle. They relate the handshake, the result-cycle pulse and the flag outputs to the destination data on the ports. The stimulus raises `in_valid` for one cycle per request. It scrambles every operand and control right after acceptance. It deliberately holds `in_valid` high while the unit is busy, and it issues back-to-back requests that land exactly in the result cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int IDX_W  = 4;
  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef logic [IDX_W-1:0] ridx_t;

  typedef struct packed {
    logic              long_f;
    logic              setf;
    ridx_t             a_idx;
    ridx_t             b_idx;
    logic [FLAG_W-1:0] flags;
  } mac_ctx_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int HI_LSB  = 16,
  parameter int LO_LSB  = 12,
  parameter int S_LSB   = 8,
  parameter int M_LSB   = 0
) (
  input  logic [INSTR_W-1:0]  instr,
  input  logic                acc_en,
  input  logic                long_en,
  input  logic                signed_en,
  input  logic                setflags,
  input  logic [DATA_W-1:0]   src_lo,
  input  logic [DATA_W-1:0]   src_hi,
  input  logic [FLAG_W-1:0]   flags_in,
  output ridx_t               m_idx,
  output ridx_t               s_idx,
  output ridx_t               lo_idx,
  output ridx_t               hi_idx,
  output logic                sgn,
  output logic [2*DATA_W-1:0] addend,
  output mac_ctx_t            ctx
);
  localparam int PROD_W = 2 * DATA_W;

  logic unused_instr;
  assign unused_instr = ^instr;

  assign m_idx  = instr[M_LSB  +: IDX_W];
  assign s_idx  = instr[S_LSB  +: IDX_W];
  assign lo_idx = instr[LO_LSB +: IDX_W];
  assign hi_idx = instr[HI_LSB +: IDX_W];

  // signed selection only has meaning for the 64-bit form
  assign sgn = long_en & signed_en;

  always_comb begin
    addend = '0;
    if (acc_en) begin
      if (long_en) addend = {src_hi, src_lo};
      else         addend = {{DATA_W{1'b0}}, src_lo};
    end
  end

  always_comb begin
    ctx        = '0;
    ctx.long_f = long_en;
    ctx.setf   = setflags;
    ctx.a_idx  = hi_idx;
    ctx.b_idx  = lo_idx;
    ctx.flags  = flags_in;
  end

  logic unused_width;
  assign unused_width = (PROD_W == 0);
endmodule

// File: rtl/mac_iter.sv
module mac_iter #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DATA_W-1:0]   mcand,
  input  logic [DATA_W-1:0]   mplier,
  input  logic                sgn,
  input  logic [2*DATA_W-1:0] addend,
  output logic                busy,
  output logic                fin,
  output logic [2*DATA_W-1:0] acc
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int STEPS  = DATA_W / DIGIT_W;
  localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

  logic [PROD_W-1:0]  mcand_sh;
  logic [DATA_W-1:0]  mplier_q;
  logic               sgn_q;
  logic [CNT_W-1:0]   cnt;
  logic               run;
  logic               fin_q;
  logic [PROD_W-1:0]  acc_q;

  logic [DIGIT_W-1:0] digit;
  logic               last;
  logic [PROD_W-1:0]  pp;

  assign digit = mplier_q[DIGIT_W-1:0];
  assign last  = (cnt == LAST_CNT);

  // the top digit of a signed multiplier carries negative weight
  always_comb begin
    pp = mcand_sh * PROD_W'(digit);
    if (sgn_q && last && digit[DIGIT_W-1])
      pp = pp - (mcand_sh << DIGIT_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_sh <= '0;
      mplier_q <= '0;
      sgn_q    <= 1'b0;
      cnt      <= '0;
      run      <= 1'b0;
      fin_q    <= 1'b0;
      acc_q    <= '0;
    end else begin
      fin_q <= run & last;
      if (load && !run) begin
        mcand_sh <= sgn ? {{DATA_W{mcand[DATA_W-1]}}, mcand}
                        : {{DATA_W{1'b0}}, mcand};
        mplier_q <= mplier;
        sgn_q    <= sgn;
        cnt      <= '0;
        run      <= 1'b1;
        acc_q    <= addend;
      end else if (run) begin
        acc_q    <= acc_q + pp;
        mcand_sh <= mcand_sh << DIGIT_W;
        mplier_q <= mplier_q >> DIGIT_W;
        cnt      <= cnt + 1'b1;
        if (last) run <= 1'b0;
      end
    end
  end

  assign busy = run;
  assign fin  = fin_q;
  assign acc  = acc_q;
endmodule

// File: rtl/mac_flag_gen.sv
module mac_flag_gen
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                done,
  input  mac_ctx_t            ctx,
  input  logic [2*DATA_W-1:0] result,
  output logic                flags_we,
  output logic [FLAG_W-1:0]   flags_out
);
  localparam int PROD_W = 2 * DATA_W;

  logic neg, zero;

  always_comb begin
    if (ctx.long_f) begin
      neg  = result[PROD_W-1];
      zero = ~|result;
    end else begin
      neg  = result[DATA_W-1];
      zero = ~|result[DATA_W-1:0];
    end
  end

  // carry and overflow hold their previous values
  always_comb begin
    flags_out         = ctx.flags;
    flags_out[FLAG_N] = neg;
    flags_out[FLAG_Z] = zero;
  end

  assign flags_we = done & ctx.setf;
endmodule

// File: rtl/regfield_mac.sv
module regfield_mac
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] instr,
  input  logic               acc_en,
  input  logic               long_en,
  input  logic               signed_en,
  input  logic               setflags,
  output logic [3:0]         rsrc_m_idx,
  output logic [3:0]         rsrc_s_idx,
  output logic [3:0]         rsrc_lo_idx,
  output logic [3:0]         rsrc_hi_idx,
  input  logic [DATA_W-1:0]  src_m,
  input  logic [DATA_W-1:0]  src_s,
  input  logic [DATA_W-1:0]  src_lo,
  input  logic [DATA_W-1:0]  src_hi,
  input  logic [3:0]         flags_in,
  output logic               done,
  output logic [3:0]         dst_a_idx,
  output logic [3:0]         dst_b_idx,
  output logic [DATA_W-1:0]  dst_a_data,
  output logic [DATA_W-1:0]  dst_b_data,
  output logic               dst_a_we,
  output logic               dst_b_we,
  output logic               flags_we,
  output logic [3:0]         flags_out
);
  localparam int PROD_W = 2 * DATA_W;

  logic              accept;
  logic              busy;
  logic              fin;
  logic              sgn;
  logic [PROD_W-1:0] addend;
  logic [PROD_W-1:0] acc;
  mac_ctx_t          ctx_d, ctx_q;

  mac_decode #(
    .DATA_W (DATA_W),
    .INSTR_W(INSTR_W)
  ) u_decode (
    .instr    (instr),
    .acc_en   (acc_en),
    .long_en  (long_en),
    .signed_en(signed_en),
    .setflags (setflags),
    .src_lo   (src_lo),
    .src_hi   (src_hi),
    .flags_in (flags_in),
    .m_idx    (rsrc_m_idx),
    .s_idx    (rsrc_s_idx),
    .lo_idx   (rsrc_lo_idx),
    .hi_idx   (rsrc_hi_idx),
    .sgn      (sgn),
    .addend   (addend),
    .ctx      (ctx_d)
  );

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx_q <= '0;
    else if (accept) ctx_q <= ctx_d;
  end

  mac_iter #(
    .DATA_W (DATA_W),
    .DIGIT_W(DIGIT_W)
  ) u_iter (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .mcand (src_m),
    .mplier(src_s),
    .sgn   (sgn),
    .addend(addend),
    .busy  (busy),
    .fin   (fin),
    .acc   (acc)
  );

  mac_flag_gen #(
    .DATA_W(DATA_W)
  ) u_flags (
    .done     (fin),
    .ctx      (ctx_q),
    .result   (acc),
    .flags_we (flags_we),
    .flags_out(flags_out)
  );

  assign done       = fin;
  assign dst_a_idx  = ctx_q.a_idx;
  assign dst_b_idx  = ctx_q.b_idx;
  assign dst_a_data = ctx_q.long_f ? acc[PROD_W-1:DATA_W] : acc[DATA_W-1:0];
  assign dst_b_data = acc[DATA_W-1:0];
  assign dst_a_we   = fin;
  assign dst_b_we   = fin & ctx_q.long_f;
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int DATA_W = 32,
  parameter int LAT    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              done,
  input logic              dst_a_we,
  input logic              dst_b_we,
  input logic              flags_we,
  input logic [3:0]        flags_out,
  input logic [DATA_W-1:0] dst_a_data,
  input logic [DATA_W-1:0] dst_b_data
);
  logic [7:0] since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    since_acc <= '0;
    else if (in_valid && in_ready)                 since_acc <= 8'd1;
    else if (since_acc != 0 && since_acc < 8'd200) since_acc <= since_acc + 8'd1;
  end

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_acc == 8'(LAT + 1)));

  assert_we_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_a_we || dst_b_we) |-> done);

  assert_a_we_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dst_a_we);

  assert_flag_we_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> done);

  assert_short_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && !dst_b_we) |->
      (flags_out[3] == dst_a_data[DATA_W-1] && flags_out[2] == (dst_a_data == '0)));

  assert_long_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && dst_b_we) |->
      (flags_out[3] == dst_a_data[DATA_W-1] &&
       flags_out[2] == (dst_a_data == '0 && dst_b_data == '0)));
endmodule

bind regfield_mac mac_checker #(.DATA_W(DATA_W)) u_mac_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .done      (done),
  .dst_a_we  (dst_a_we),
  .dst_b_we  (dst_b_we),
  .flags_we  (flags_we),
  .flags_out (flags_out),
  .dst_a_data(dst_a_data),
  .dst_b_data(dst_b_data)
);

// File: tb/regfield_mac_bench.sv
module regfield_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic        acc_en = 1'b0, long_en = 1'b0, signed_en = 1'b0, setflags = 1'b0;
  logic [3:0]  rsrc_m_idx, rsrc_s_idx, rsrc_lo_idx, rsrc_hi_idx;
  logic [31:0] src_m = '0, src_s = '0, src_lo = '0, src_hi = '0;
  logic [3:0]  flags_in = '0;
  logic        done;
  logic [3:0]  dst_a_idx, dst_b_idx;
  logic [31:0] dst_a_data, dst_b_data;
  logic        dst_a_we, dst_b_we, flags_we;
  logic [3:0]  flags_out;

  always #4 clk = ~clk;

  regfield_mac u_regfield_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .acc_en(acc_en), .long_en(long_en), .signed_en(signed_en),
    .setflags(setflags), .rsrc_m_idx(rsrc_m_idx), .rsrc_s_idx(rsrc_s_idx),
    .rsrc_lo_idx(rsrc_lo_idx), .rsrc_hi_idx(rsrc_hi_idx), .src_m(src_m),
    .src_s(src_s), .src_lo(src_lo), .src_hi(src_hi), .flags_in(flags_in),
    .done(done), .dst_a_idx(dst_a_idx), .dst_b_idx(dst_b_idx),
    .dst_a_data(dst_a_data), .dst_b_data(dst_b_data), .dst_a_we(dst_a_we),
    .dst_b_we(dst_b_we), .flags_we(flags_we), .flags_out(flags_out)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  ai;
    logic [3:0]  bi;
    bit          lng;
    bit          sf;
    bit          n;
    bit          z;
    int          cyc;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   ended = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] hi, lo, s, m);
    return {12'hE00, hi, lo, s, 4'h9, m};
  endfunction

  // monitor: pops the scoreboard in each result cycle
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && !ended) begin
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11", "unexpected result", 64'(done), 64'd0);
        end else begin
          e = q.pop_front();
          chk(cyc == e.cyc, "R10", "done cycle", 64'(cyc), 64'(e.cyc));
          chk(dst_a_data == e.a, e.req, "dst_a_data", 64'(dst_a_data), 64'(e.a));
          if (e.lng)
            chk(dst_b_data == e.b, e.req, "dst_b_data", 64'(dst_b_data), 64'(e.b));
          chk(dst_a_idx == e.ai && (!e.lng || dst_b_idx == e.bi), "R1", "dest idx",
              64'({dst_a_idx, dst_b_idx}), 64'({e.ai, e.bi}));
          chk(dst_a_we && (dst_b_we == e.lng), "R6", "write enables",
              64'({dst_a_we, dst_b_we}), 64'({1'b1, e.lng}));
          chk(flags_we == e.sf, "R9", "flags_we", 64'(flags_we), 64'(e.sf));
          if (e.sf)
            chk(flags_out[3:2] == {e.n, e.z}, e.lng ? "R8" : "R7", "N,Z",
                64'(flags_out[3:2]), 64'({e.n, e.z}));
        end
      end else if (dst_a_we || dst_b_we || flags_we) begin
        chk(1'b0, "R6", "enable outside result cycle",
            64'({dst_a_we, dst_b_we, flags_we}), 64'd0);
      end
    end
  end

  task automatic issue(input logic [31:0] ins, input logic [31:0] rm, rs, lo, hi,
                       input bit acc, lng, sgn, sf, input string req);
    exp_t e;
    logic [63:0] p, em, es;
    while (!in_ready) @(negedge clk);
    instr = ins; src_m = rm; src_s = rs; src_lo = lo; src_hi = hi;
    acc_en = acc; long_en = lng; signed_en = sgn; setflags = sf;
    flags_in = 4'b0011; in_valid = 1'b1;
    #1;
    chk({rsrc_hi_idx, rsrc_lo_idx, rsrc_s_idx, rsrc_m_idx} ==
        {ins[19:16], ins[15:12], ins[11:8], ins[3:0]}, "R1", "read idx",
        64'({rsrc_hi_idx, rsrc_lo_idx, rsrc_s_idx, rsrc_m_idx}),
        64'({ins[19:16], ins[15:12], ins[11:8], ins[3:0]}));
    em = (lng && sgn) ? {{32{rm[31]}}, rm} : {32'd0, rm};
    es = (lng && sgn) ? {{32{rs[31]}}, rs} : {32'd0, rs};
    p  = em * es;
    if (acc) p = p + (lng ? {hi, lo} : {32'd0, lo});
    e.a   = lng ? p[63:32] : p[31:0];
    e.b   = p[31:0];
    e.ai  = ins[19:16];
    e.bi  = ins[15:12];
    e.lng = lng;
    e.sf  = sf;
    e.n   = lng ? p[63] : p[31];
    e.z   = lng ? (p == 64'd0) : (p[31:0] == 32'd0);
    e.cyc = cyc + 5;
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    // R12: scramble everything after acceptance
    instr = $urandom; src_m = $urandom; src_s = $urandom;
    src_lo = $urandom; src_hi = $urandom; flags_in = 4'($urandom);
    acc_en = ~acc; long_en = ~lng; signed_en = ~sgn; setflags = ~sf;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      chk(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(in_ready && !done && !dst_a_we && !dst_b_we && !flags_we, "R13", "reset state",
        64'({in_ready, done, dst_a_we, dst_b_we, flags_we}), 64'b10000);
    rst_n = 1'b1;
    @(negedge clk);

    issue(mk(4'd2, 4'd0, 4'd3, 4'd4), 32'd7, 32'd6, 32'd0, 32'd0, 0, 0, 0, 0, "R2");
    issue(mk(4'd5, 4'd1, 4'd6, 4'd7), 32'hFFFF_FFFF, 32'd2, 32'd9, 32'd9, 0, 0, 1, 1, "R2");
    issue(mk(4'd8, 4'd9, 4'd10, 4'd11), 32'd3, 32'd5, 32'd100, 32'd0, 1, 0, 0, 1, "R3");
    issue(mk(4'd1, 4'd2, 4'd3, 4'd4), 32'h0001_0000, 32'h0001_0000, 32'd0, 32'd0, 0, 0, 0, 1, "R7");
    issue(mk(4'd3, 4'd4, 4'd5, 4'd6), 32'h8000_0000, 32'd1, 32'd0, 32'd0, 0, 0, 0, 1, "R7");
    issue(mk(4'd12, 4'd13, 4'd1, 4'd2), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, 0, 1, 0, 1, "R4");
    issue(mk(4'd14, 4'd15, 4'd1, 4'd2), 32'hFFFF_FFFF, 32'hFFFF_FFFF,
          32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 1, "R4");
    issue(mk(4'd4, 4'd5, 4'd6, 4'd7), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, 0, 1, 1, 1, "R5");
    issue(mk(4'd6, 4'd7, 4'd8, 4'd9), 32'hFFFF_FFFD, 32'd7, 32'd5, 32'd0, 1, 1, 1, 1, "R5");
    issue(mk(4'd1, 4'd0, 4'd2, 4'd3), 32'h8000_0000, 32'h8000_0000, 32'd0, 32'd0, 0, 1, 1, 0, "R5");
    issue(mk(4'd2, 4'd3, 4'd4, 4'd5), 32'd0, 32'h1234_5678, 32'd0, 32'd0, 1, 1, 1, 1, "R8");
    issue(mk(4'd7, 4'd8, 4'd9, 4'd10), 32'h0001_0000, 32'h0001_0000, 32'd0, 32'd0, 0, 1, 0, 1, "R8");
    // R12: long accumulate reads pair present at acceptance, inputs scrambled after
    issue(mk(4'd9, 4'd10, 4'd11, 4'd12), 32'h1234_5678, 32'h9ABC_DEF0,
          32'hDEAD_BEEF, 32'h0BAD_F00D, 1, 1, 0, 1, "R12");

    // R11: a request held while busy is ignored
    issue(mk(4'd1, 4'd2, 4'd3, 4'd4), 32'd11, 32'd13, 32'd0, 32'd0, 0, 0, 0, 0, "R11");
    in_valid = 1'b1; src_m = 32'd999; src_s = 32'd999;
    chk(!in_ready, "R11", "in_ready while busy", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk(!in_ready, "R11", "in_ready while busy", 64'(in_ready), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;

    // R11: requests accepted in the result cycle, back to back
    issue(mk(4'd3, 4'd3, 4'd1, 4'd2), 32'h0000_FFFF, 32'h0000_FFFF, 32'd1, 32'd0, 1, 0, 0, 1, "R3");
    issue(mk(4'd4, 4'd5, 4'd1, 4'd2), 32'hFFFF_FFFF, 32'd1, 32'd0, 32'd0, 0, 1, 1, 1, "R5");
    issue(mk(4'd6, 4'd7, 4'd1, 4'd2), 32'hCAFE_0001, 32'h0000_0100, 32'd5, 32'd6, 1, 1, 0, 0, "R4");

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R10", "pending results", 64'(q.size()), 64'd0);
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule